// File: doc/BRIEF.md
# Key-Folded Table-Driven AES Encryption Engine

This block encrypts one 128-bit block at a time with AES, using 10, 12 or 14 rounds. Each round is carried out as a pure table lookup followed by an XOR network. Every round owns sixteen lookup tables, one for each byte position of the state. The round-key byte for that position has already been merged into the table contents before the tables are loaded. As a result, no key addition happens before a lookup. One 32-bit table entry holds the substituted byte of (input byte XOR key byte), already spread across its output column. For every round except the last, that spread includes the column-mixing coefficients. In the final round the entry carries only the bare substituted byte, in its own row. A separate 128-bit whitening register is XORed in after the last round.

Software computes the tables and the whitening key and writes them through a configuration port. The port accepts one 32-bit word per cycle, and only while the engine is idle. Plaintext enters on a valid/ready handshake, along with a round-count select. The ciphertext leaves on a one-cycle valid strobe, exactly two cycles per round after acceptance.

Top module: `keyfold_aes_core`

## Requirements
- R1: After synchronous reset, in_ready is 1, out_valid is 0 and cfg_err is 0.
- R2: A block is accepted on a clock edge where in_valid and in_ready are both 1. From the following cycle in_ready is 0. out_valid is 1 for exactly one cycle, starting 2·N cycles after the accepting edge, where N is the round count. in_ready is 0 during that cycle and returns to 1 in the cycle after it.
- R3: State byte n is in_data[127-8n -: 8], at row n mod 4 and column n div 4. Table position p serves state byte p. A table word carries output row m in bits [31-8m -: 8]. Round output column c is in bits [127-32c -: 32]. It is the XOR, over rows i, of the word read from position 4·((c+i) mod 4)+i of the current round, indexed by that position's state byte.
- R4: rounds_sel 0 selects 10 rounds, 1 selects 12, and 2 or 3 select 14. The value is sampled only at acceptance; changing it during a block has no effect on that block.
- R5: out_data equals the last round's XOR result XORed with the whitening key. A whitening write (cfg_key_sel=1) puts cfg_wdata into key bits [127-32w -: 32], with w = cfg_idx[1:0].
- R6: A table write (cfg_key_sel=0) performed while idle stores cfg_wdata at entry cfg_idx of the table for round cfg_round, position cfg_pos. Rounds are numbered 0 to N-1 and round N-1 is the final round. The new contents are used by blocks accepted later.
- R7: A configuration write made while a block is in progress changes neither the tables nor the whitening key. For each such write, cfg_err is 1 in the following cycle only.
- R8: When the tables hold the S-box with standard AES-128 round keys folded in, and the whitening key holds the last round key, the output equals standard AES-128 encryption.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Plaintext offered |
| in_ready | output | 1 | Engine idle, plaintext can be taken |
| in_data | input | 128 | Plaintext block |
| rounds_sel | input | 2 | Round count select |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_key_sel | input | 1 | 1: whitening key word, 0: table entry |
| cfg_round | input | 4 | Table round index |
| cfg_pos | input | 4 | Table byte position |
| cfg_idx | input | 8 | Table entry index, or key word index in bits 1:0 |
| cfg_wdata | input | 32 | Write data |
| cfg_err | output | 1 | Pulse for a write rejected while busy |
| out_valid | output | 1 | Ciphertext strobe |
| out_data | output | 128 | Ciphertext block |

## Verification
The standard AES-128 test vector is checked against its published ciphertext, which shows that the byte routing, the row rotation and the final-round handling agree with real AES. All-zero, all-one and mixed plaintexts are then run in 10-, 12- and 14-round settings, with unrelated folded keys in the upper rounds. These runs separate a wrong round count, a stale table round and a missing whitening step. Back-to-back blocks with in_valid held high pin down the idle cycle between blocks. Writes issued mid-block and a round select changed mid-block must leave both that block and the next one unchanged.

// File: rtl/kf_aes_pkg.sv
package kf_aes_pkg;
  localparam int BYTE_W      = 8;
  localparam int ROWS        = 4;
  localparam int COLS        = 4;
  localparam int NPOS        = ROWS * COLS;
  localparam int WORD_W      = ROWS * BYTE_W;
  localparam int BLK_W       = NPOS * BYTE_W;
  localparam int LUT_ENTRIES = 1 << BYTE_W;
  localparam int MAX_ROUNDS  = 14;
  localparam int RND_W       = $clog2(MAX_ROUNDS + 1);
  localparam int POS_W       = $clog2(NPOS);

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_LOOK = 2'd1,
    ST_COMB = 2'd2,
    ST_DONE = 2'd3
  } kf_state_e;

  function automatic logic [RND_W-1:0] rounds_of(input logic [1:0] sel);
    case (sel)
      2'd0:    rounds_of = RND_W'(10);
      2'd1:    rounds_of = RND_W'(12);
      default: rounds_of = RND_W'(14);
    endcase
  endfunction
endpackage

// File: rtl/kf_table_ram.sv
module kf_table_ram #(
  parameter int DATA_W = 32,
  parameter int DEPTH  = 3584,
  parameter int ADDR_W = 12
) (
  input  logic              clk,
  input  logic              we,
  input  logic [ADDR_W-1:0] waddr,
  input  logic [DATA_W-1:0] wdata,
  input  logic [ADDR_W-1:0] raddr,
  output logic [DATA_W-1:0] rdata
);
  logic [DATA_W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we && (int'(waddr) < DEPTH)) mem[waddr] <= wdata;
    rdata <= mem[raddr];
  end
endmodule

// File: rtl/kf_combine.sv
module kf_combine import kf_aes_pkg::*; #(
  parameter int N_ROWS = ROWS,
  parameter int N_COLS = COLS,
  parameter int W_W    = WORD_W
) (
  input  logic [N_ROWS*N_COLS-1:0][W_W-1:0] words,
  output logic [N_COLS*W_W-1:0]             mixed
);
  for (genvar c = 0; c < N_COLS; c++) begin : g_col
    logic [W_W-1:0] col;
    always_comb begin
      col = '0;
      for (int i = 0; i < N_ROWS; i++) begin
        col ^= words[N_ROWS * ((c + i) % N_COLS) + i];
      end
    end
    assign mixed[N_COLS*W_W-1-W_W*c -: W_W] = col;
  end
endmodule

// File: rtl/kf_round_ctrl.sv
module kf_round_ctrl import kf_aes_pkg::*; #(
  parameter int R_W = RND_W
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           in_valid,
  input  logic [1:0]     rounds_sel,
  input  logic           cfg_we,
  output logic           in_ready,
  output logic           accept,
  output logic           step,
  output logic           last,
  output logic           idle,
  output logic [R_W-1:0] round_idx,
  output logic           out_valid,
  output logic           cfg_err
);
  kf_state_e      fsm_q;
  logic [R_W-1:0] nrounds_q;
  logic           in_comb;

  assign idle     = (fsm_q == ST_IDLE);
  assign in_ready = idle;
  assign accept   = idle && in_valid;
  assign in_comb  = (fsm_q == ST_COMB);
  assign last     = in_comb && (round_idx == nrounds_q - 1'b1);
  assign step     = in_comb && !last;

  always_ff @(posedge clk) begin
    if (rst) begin
      fsm_q     <= ST_IDLE;
      round_idx <= '0;
      nrounds_q <= R_W'(rounds_of(2'd0));
      out_valid <= 1'b0;
      cfg_err   <= 1'b0;
    end else begin
      cfg_err   <= cfg_we && !idle;
      out_valid <= last;
      case (fsm_q)
        ST_IDLE: if (accept) begin
          round_idx <= '0;
          nrounds_q <= R_W'(rounds_of(rounds_sel));
          fsm_q     <= ST_LOOK;
        end
        ST_LOOK: fsm_q <= ST_COMB;
        ST_COMB: begin
          if (last) fsm_q <= ST_DONE;
          else begin
            round_idx <= round_idx + 1'b1;
            fsm_q     <= ST_LOOK;
          end
        end
        default: fsm_q <= ST_IDLE;
      endcase
    end
  end

  p_accept_drops_ready_r2: assert property (@(posedge clk) disable iff (rst)
    (in_valid && in_ready) |=> !in_ready);
  p_valid_single_r2: assert property (@(posedge clk) disable iff (rst)
    out_valid |=> !out_valid);
  p_ready_after_valid_r2: assert property (@(posedge clk) disable iff (rst)
    out_valid |=> in_ready);
  p_no_ready_with_valid_r2: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> !in_ready);
  p_round_in_range_r4: assert property (@(posedge clk) disable iff (rst)
    !idle |-> (round_idx < nrounds_q));
  p_round_count_legal_r4: assert property (@(posedge clk) disable iff (rst)
    !idle |-> (nrounds_q == R_W'(10) || nrounds_q == R_W'(12) || nrounds_q == R_W'(14)));
  p_err_needs_write_r7: assert property (@(posedge clk) disable iff (rst)
    cfg_err |-> ($past(cfg_we) && !$past(in_ready)));
endmodule

// File: rtl/keyfold_aes_core.sv
module keyfold_aes_core import kf_aes_pkg::*; #(
  parameter int N_ROUNDS_MAX = MAX_ROUNDS,
  parameter int ENTRY_W      = WORD_W
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               in_valid,
  output logic               in_ready,
  input  logic [BLK_W-1:0]   in_data,
  input  logic [1:0]         rounds_sel,
  input  logic               cfg_we,
  input  logic               cfg_key_sel,
  input  logic [RND_W-1:0]   cfg_round,
  input  logic [POS_W-1:0]   cfg_pos,
  input  logic [BYTE_W-1:0]  cfg_idx,
  input  logic [ENTRY_W-1:0] cfg_wdata,
  output logic               cfg_err,
  output logic               out_valid,
  output logic [BLK_W-1:0]   out_data
);
  localparam int DEPTH  = N_ROUNDS_MAX * LUT_ENTRIES;
  localparam int ADDR_W = RND_W + BYTE_W;
  localparam int KWORDS = BLK_W / ENTRY_W;
  localparam int KW_W   = $clog2(KWORDS);

  logic                           accept, step, last, idle;
  logic [RND_W-1:0]               round_idx;
  logic [BLK_W-1:0]               state_q;
  logic [BLK_W-1:0]               wkey_q;
  logic [BLK_W-1:0]               mixed;
  logic [NPOS-1:0][ENTRY_W-1:0]   lut_out;
  logic                           tbl_we;
  logic [KW_W-1:0]                kword;

  kf_round_ctrl #(.R_W(RND_W)) u_ctrl (
    .clk       (clk),
    .rst       (rst),
    .in_valid  (in_valid),
    .rounds_sel(rounds_sel),
    .cfg_we    (cfg_we),
    .in_ready  (in_ready),
    .accept    (accept),
    .step      (step),
    .last      (last),
    .idle      (idle),
    .round_idx (round_idx),
    .out_valid (out_valid),
    .cfg_err   (cfg_err)
  );

  assign tbl_we = cfg_we && !cfg_key_sel && idle && (int'(cfg_round) < N_ROUNDS_MAX);
  assign kword  = cfg_idx[KW_W-1:0];

  for (genvar p = 0; p < NPOS; p++) begin : g_lut
    logic [ADDR_W-1:0] raddr;
    assign raddr = {round_idx, state_q[BLK_W-1-BYTE_W*p -: BYTE_W]};
    kf_table_ram #(
      .DATA_W(ENTRY_W),
      .DEPTH (DEPTH),
      .ADDR_W(ADDR_W)
    ) u_ram (
      .clk  (clk),
      .we   (tbl_we && (cfg_pos == POS_W'(p))),
      .waddr({cfg_round, cfg_idx}),
      .wdata(cfg_wdata),
      .raddr(raddr),
      .rdata(lut_out[p])
    );
  end

  kf_combine #(.N_ROWS(ROWS), .N_COLS(COLS), .W_W(ENTRY_W)) u_comb (
    .words(lut_out),
    .mixed(mixed)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q  <= '0;
      wkey_q   <= '0;
      out_data <= '0;
    end else begin
      if (accept)    state_q <= in_data;
      else if (step) state_q <= mixed;
      if (last) out_data <= mixed ^ wkey_q;
      if (cfg_we && cfg_key_sel && idle)
        wkey_q[BLK_W-1-ENTRY_W*kword -: ENTRY_W] <= cfg_wdata;
    end
  end

  p_wkey_locked_busy_r7: assert property (@(posedge clk) disable iff (rst)
    !in_ready |=> $stable(wkey_q));
  p_out_hold_after_valid_r5: assert property (@(posedge clk) disable iff (rst)
    out_valid |=> $stable(out_data));
  p_state_frozen_done_r3: assert property (@(posedge clk) disable iff (rst)
    out_valid |=> $stable(state_q));
endmodule

// File: tb/keyfold_aes_core_bench.sv
module keyfold_aes_core_bench;
  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         in_valid = 1'b0;
  logic         in_ready;
  logic [127:0] in_data = '0;
  logic [1:0]   rounds_sel = 2'd0;
  logic         cfg_we = 1'b0;
  logic         cfg_key_sel = 1'b0;
  logic [3:0]   cfg_round = '0;
  logic [3:0]   cfg_pos = '0;
  logic [7:0]   cfg_idx = '0;
  logic [31:0]  cfg_wdata = '0;
  logic         cfg_err;
  logic         out_valid;
  logic [127:0] out_data;

  int tests = 0;
  int fails = 0;
  bit done = 0;
  string data_req = "R3";

  logic [7:0]   sbox [256];
  logic [127:0] rk [15];
  logic [127:0] last_out;

  logic         m_busy, m_valid, m_err;
  int           m_cnt;
  logic [127:0] m_exp;

  always #5 clk = ~clk;

  keyfold_aes_core u_keyfold_aes_core (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
    .in_data(in_data), .rounds_sel(rounds_sel), .cfg_we(cfg_we),
    .cfg_key_sel(cfg_key_sel), .cfg_round(cfg_round), .cfg_pos(cfg_pos),
    .cfg_idx(cfg_idx), .cfg_wdata(cfg_wdata), .cfg_err(cfg_err),
    .out_valid(out_valid), .out_data(out_data)
  );

  function automatic logic [7:0] xt(input logic [7:0] a);
    xt = {a[6:0], 1'b0} ^ (a[7] ? 8'h1b : 8'h00);
  endfunction

  function automatic logic [7:0] gmul(input logic [7:0] a, input logic [7:0] b);
    logic [7:0] r = 8'h00, x = a;
    for (int k = 0; k < 8; k++) begin
      if (b[k]) r ^= x;
      x = xt(x);
    end
    gmul = r;
  endfunction

  function automatic int nr_of(input logic [1:0] s);
    nr_of = (s == 2'd0) ? 10 : (s == 2'd1) ? 12 : 14;
  endfunction

  function automatic logic [127:0] aes_ref(input logic [127:0] pt, input int nr);
    logic [7:0] s [16];
    logic [7:0] t [16];
    logic [127:0] res;
    for (int n = 0; n < 16; n++) s[n] = pt[127-8*n -: 8];
    for (int r = 0; r < nr; r++) begin
      for (int n = 0; n < 16; n++) s[n] = sbox[s[n] ^ rk[r][127-8*n -: 8]];
      for (int c = 0; c < 4; c++)
        for (int i = 0; i < 4; i++) t[4*c+i] = s[4*((c+i)%4)+i];
      if (r < nr - 1) begin
        for (int c = 0; c < 4; c++) begin
          s[4*c+0] = gmul(t[4*c],2) ^ gmul(t[4*c+1],3) ^ t[4*c+2] ^ t[4*c+3];
          s[4*c+1] = t[4*c] ^ gmul(t[4*c+1],2) ^ gmul(t[4*c+2],3) ^ t[4*c+3];
          s[4*c+2] = t[4*c] ^ t[4*c+1] ^ gmul(t[4*c+2],2) ^ gmul(t[4*c+3],3);
          s[4*c+3] = gmul(t[4*c],3) ^ t[4*c+1] ^ t[4*c+2] ^ gmul(t[4*c+3],2);
        end
      end else begin
        for (int n = 0; n < 16; n++) s[n] = t[n];
      end
    end
    for (int n = 0; n < 16; n++) res[127-8*n -: 8] = s[n] ^ rk[nr][127-8*n -: 8];
    aes_ref = res;
  endfunction

  function automatic logic [31:0] entry(input int r, input int p, input int x, input bit fin);
    logic [7:0]  b;
    logic [31:0] w = '0;
    int i = p % 4;
    b = sbox[8'(x) ^ rk[r][127-8*p -: 8]];
    for (int m = 0; m < 4; m++) begin
      int d = (i - m) & 3;
      if (fin) w[31-8*m -: 8] = (m == i) ? b : 8'h00;
      else     w[31-8*m -: 8] = gmul(b, (d == 0) ? 8'd2 : (d == 1) ? 8'd3 : 8'd1);
    end
    entry = w;
  endfunction

  task automatic chk(input string req, input logic [127:0] act, input logic [127:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // reference model, cycle by cycle
  always @(posedge clk) begin
    if (rst) begin
      m_busy <= 1'b0; m_valid <= 1'b0; m_err <= 1'b0; m_cnt <= 0;
    end else begin
      m_err <= cfg_we && m_busy;
      if (m_valid) begin
        m_valid <= 1'b0; m_busy <= 1'b0;
      end else if (!m_busy) begin
        if (in_valid) begin
          m_busy <= 1'b1;
          m_cnt  <= 2 * nr_of(rounds_sel) - 1;
          m_exp  <= aes_ref(in_data, nr_of(rounds_sel));
        end
      end else if (m_cnt == 0) m_valid <= 1'b1;
      else m_cnt <= m_cnt - 1;
    end
  end

  always @(negedge clk) begin
    if (!rst) begin
      chk("R2 in_ready", {127'd0, in_ready}, {127'd0, !m_busy});
      chk("R2 out_valid", {127'd0, out_valid}, {127'd0, m_valid});
      chk("R7 cfg_err", {127'd0, cfg_err}, {127'd0, m_err});
      if (m_valid) begin
        chk(data_req, out_data, m_exp);
        last_out = out_data;
      end
    end
  end

  task automatic load_round(input int r, input bit fin);
    for (int p = 0; p < 16; p++)
      for (int x = 0; x < 256; x++) begin
        @(negedge clk);
        cfg_we = 1'b1; cfg_key_sel = 1'b0;
        cfg_round = 4'(r); cfg_pos = 4'(p); cfg_idx = 8'(x);
        cfg_wdata = entry(r, p, x, fin);
      end
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic load_wkey(input logic [127:0] k);
    for (int w = 0; w < 4; w++) begin
      @(negedge clk);
      cfg_we = 1'b1; cfg_key_sel = 1'b1; cfg_idx = 8'(w);
      cfg_wdata = k[127-32*w -: 32];
    end
    @(negedge clk);
    cfg_we = 1'b0; cfg_key_sel = 1'b0;
  endtask

  task automatic wait_idle();
    @(negedge clk);
    while (m_busy) @(negedge clk);
  endtask

  task automatic run_block(input logic [127:0] pt, input logic [1:0] sel);
    wait_idle();
    in_valid = 1'b1; in_data = pt; rounds_sel = sel;
    @(negedge clk);
    in_valid = 1'b0;
    wait_idle();
  endtask

  task automatic expand128(input logic [127:0] key);
    logic [31:0] w [44];
    logic [31:0] t;
    logic [7:0]  rc = 8'h01;
    for (int i = 0; i < 4; i++) w[i] = key[127-32*i -: 32];
    for (int i = 4; i < 44; i++) begin
      t = w[i-1];
      if (i % 4 == 0) begin
        t = {t[23:0], t[31:24]};
        t = {sbox[t[31:24]], sbox[t[23:16]], sbox[t[15:8]], sbox[t[7:0]]};
        t ^= {rc, 24'h0};
        rc = xt(rc);
      end
      w[i] = w[i-4] ^ t;
    end
    for (int r = 0; r < 11; r++) rk[r] = {w[4*r], w[4*r+1], w[4*r+2], w[4*r+3]};
  endtask

  function automatic logic [127:0] mk_key(input int r);
    logic [31:0] a = 32'h9e3779b9 * 32'(r + 3);
    mk_key = {a, a ^ 32'h5a5a_c3c3, a + 32'h0f1e_2d3c, ~a};
  endfunction

  initial begin
    logic [7:0] inv, b;
    for (int x = 0; x < 256; x++) begin
      inv = 8'h00;
      for (int y = 1; y < 256; y++) if (gmul(8'(x), 8'(y)) == 8'h01) inv = 8'(y);
      b = inv;
      sbox[x] = b ^ {b[6:0], b[7]} ^ {b[5:0], b[7:6]} ^ {b[4:0], b[7:5]}
                  ^ {b[3:0], b[7:4]} ^ 8'h63;
    end
    repeat (4) @(negedge clk);
    rst = 1'b0;
    // R1 reset state
    chk("R1 in_ready", {127'd0, in_ready}, 128'd1);
    chk("R1 out_valid", {127'd0, out_valid}, 128'd0);
    chk("R1 cfg_err", {127'd0, cfg_err}, 128'd0);
    // R8 substitution anchors used by the folded tables
    chk("R8 sbox", {80'd0, sbox[0], sbox[1], sbox[2], sbox[3], sbox[4], sbox[5]},
        {80'd0, 48'h637c777bf26b});

    // R8 / R6 / R5: standard 128-bit key folded into rounds 0..9
    expand128(128'h000102030405060708090a0b0c0d0e0f);
    for (int r = 0; r < 10; r++) load_round(r, r == 9);
    load_wkey(rk[10]);
    data_req = "R8";
    run_block(128'h00112233445566778899aabbccddeeff, 2'd0);
    chk("R8 known answer", last_out, 128'h69c4e0d86a7b0430d8cdb78070b4c55a);

    // R3 several patterns
    data_req = "R3";
    run_block('0, 2'd0);
    run_block('1, 2'd0);
    run_block(128'h0123456789abcdeffedcba9876543210, 2'd0);

    // R2 back-to-back with valid held
    data_req = "R2 data";
    wait_idle();
    in_valid = 1'b1; in_data = 128'hdeadbeef_00000000_cafef00d_12345678; rounds_sel = 2'd0;
    @(negedge clk);
    in_data = 128'h80000000_00000000_00000000_00000001;
    while (m_busy) @(negedge clk);
    @(negedge clk);
    in_valid = 1'b0;
    wait_idle();

    // R7 writes during a block are ignored, flagged by cfg_err
    data_req = "R7 data";
    in_valid = 1'b1; in_data = 128'h55aa55aa_0f0f0f0f_f0f0f0f0_aa55aa55; rounds_sel = 2'd0;
    @(negedge clk);
    in_valid = 1'b0;
    repeat (3) @(negedge clk);
    cfg_we = 1'b1; cfg_key_sel = 1'b0; cfg_round = 4'd0; cfg_pos = 4'd0;
    cfg_idx = 8'h55; cfg_wdata = 32'hffff_ffff;
    @(negedge clk);
    cfg_idx = 8'h00;
    @(negedge clk);
    cfg_key_sel = 1'b1; cfg_idx = 8'd0; cfg_wdata = 32'h1234_5678;
    @(negedge clk);
    cfg_we = 1'b0; cfg_key_sel = 1'b0;
    wait_idle();
    run_block(128'h55aa55aa_0f0f0f0f_f0f0f0f0_aa55aa55, 2'd0);
    run_block('0, 2'd0);

    // R4 select changed mid-block has no effect
    data_req = "R4 sampled";
    in_valid = 1'b1; in_data = 128'hfeedface_0badf00d_11112222_33334444; rounds_sel = 2'd0;
    @(negedge clk);
    in_valid = 1'b0; rounds_sel = 2'd2;
    wait_idle();

    // R4 twelve rounds: new folded keys in rounds 9..11, whitening with key 12
    for (int r = 9; r < 13; r++) rk[r] = mk_key(r);
    load_round(9, 0); load_round(10, 0); load_round(11, 1);
    load_wkey(rk[12]);
    data_req = "R4 12 rounds";
    run_block(128'h00112233445566778899aabbccddeeff, 2'd1);
    run_block('1, 2'd1);

    // R4 fourteen rounds with select 2 and 3
    for (int r = 11; r < 15; r++) rk[r] = mk_key(r + 20);
    load_round(11, 0); load_round(12, 0); load_round(13, 1);
    load_wkey(rk[14]);
    data_req = "R4 14 rounds";
    run_block(128'h00112233445566778899aabbccddeeff, 2'd2);
    run_block(128'h0123456789abcdeffedcba9876543210, 2'd3);

    // R5 whitening word change alone alters the result
    rk[14][127-32*2 -: 32] = rk[14][127-32*2 -: 32] ^ 32'h0000_0100;
    load_wkey(rk[14]);
    data_req = "R5";
    run_block(128'h0123456789abcdeffedcba9876543210, 2'd2);

    repeat (3) @(negedge clk);
    done = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      tests++; fails++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end
endmodule